// File: doc/BRIEF.md
# Output-Compare Pin Action Controller

This block sits between the compare channels of a timer and its eight port pins. Each channel has a two-bit setting: a mode bit and a level bit. When a channel's compare strobe fires, the setting decides what happens to that channel's registered output level. The level can be left alone, toggled, driven low or driven high. A nonzero setting also takes the pin away from the general-purpose port. The pin is then driven as an output carrying the timer level, whatever its direction bit says. A per-channel override mask blocks all of this and hands the pin back to the port.

Software reaches the settings through a small write/read port with two 8-bit control registers. The block also flags when the top channel or the bottom channel is free for a pulse accumulator. A channel is free when it is selected as an input, carries no timer action and is not overridden.

Top module: `oc_pin_ctrl`

## Requirements
- R1: After reset, both control registers read 0 and every channel's output level is 0. Every pin then follows the port: pin_oe equals dir_bits and pin_level equals port_data.
- R2: Address 0 holds channels 7..4 and address 1 holds channels 3..0. Within a register, channel k's mode bit sits at bit 2*(k mod 4)+1 and its level bit at bit 2*(k mod 4). A read returns exactly what was last written.
- R3: Addresses 2 and 3 read as 0, and writes to them change no control register.
- R4: With {mode,level}=01 and the mask bit clear, each strobe inverts the channel's output level on the next clock edge. Strobes on consecutive cycles toggle the level once per strobe.
- R5: With {mode,level}=10 a strobe drives the level to 0, and with 11 it drives the level to 1, both on the next clock edge. This applies only while the mask bit is clear.
- R6: With a nonzero {mode,level} and the mask bit clear, pin_oe is 1 and pin_level is the channel's output level, whatever dir_bits holds.
- R7: With {mode,level}=00, or with the mask bit set, pin_oe equals dir_bits and pin_level equals port_data. A strobe in that state leaves the output level unchanged.
- R8: A control write in the same cycle as a strobe takes effect from the next cycle. The strobe acts with the previous setting.
- R9: pa_free_hi is 1 exactly when ios_sel[7] is 1, channel 7's pair is 00 and ovr_mask[7] is 0. pa_free_lo follows the same rule for channel 0.
- R10: Without a strobe, a channel's output level holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_addr | input | 2 | Control register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| cmp_evt | input | 8 | Per-channel single-cycle compare strobes |
| ovr_mask | input | 8 | Per-channel override mask; 1 blocks the timer action |
| ios_sel | input | 8 | Per-channel input/output select bits |
| dir_bits | input | 8 | Port direction register bits |
| port_data | input | 8 | Port data register bits |
| pin_level | output | 8 | Level presented to each pin |
| pin_oe | output | 8 | Output enable for each pin |
| pa_free_hi | output | 1 | Channel 7 free for pulse-accumulator use |
| pa_free_lo | output | 1 | Channel 0 free for pulse-accumulator use |

## Verification
The assertions assume that cmp_evt, ovr_mask and the register port change only between clock edges and never carry X after reset. The bench drives every input on the falling edge, so this holds. The assertions also assume that a strobe may repeat on consecutive cycles, and the bench exercises that case on purpose. Register writes come one per cycle, including one aligned with a strobe, and the undefined addresses are written to show they are ignored.

// File: rtl/oc_pin_pkg.sv
package oc_pin_pkg;

  typedef enum logic [1:0] {
    ACT_OFF    = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } oc_act_e;

  // level after a compare event under a given action
  function automatic logic act_next_level(input oc_act_e act, input logic cur);
    case (act)
      ACT_TOGGLE: act_next_level = ~cur;
      ACT_CLEAR:  act_next_level = 1'b0;
      ACT_SET:    act_next_level = 1'b1;
      default:    act_next_level = cur;
    endcase
  endfunction

endpackage

// File: rtl/oc_ctrl_regs.sv
module oc_ctrl_regs #(
  parameter int NCH    = 8,
  parameter int REG_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [2*NCH-1:0]  ctrl_bits
);
  localparam int TOT_W = 2 * NCH;
  localparam int NREG  = TOT_W / REG_W;

  logic [TOT_W-1:0] ctrl_q;
  logic             wr_undef;

  assign wr_undef = reg_we && ({1'b0, reg_addr} >= (ADDR_W+1)'(NREG));

  // address 0 maps to the most significant register slice
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int SL = (NREG - 1 - g) * REG_W;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ctrl_q[SL +: REG_W] <= '0;
      else if (reg_we && reg_addr == ADDR_W'(g))
        ctrl_q[SL +: REG_W] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NREG; k++)
      if (reg_addr == ADDR_W'(k))
        reg_rdata = ctrl_q[(NREG-1-k)*REG_W +: REG_W];
  end

  assign ctrl_bits = ctrl_q;

  // R3
  undef_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_undef |=> $stable(ctrl_q));

  // R2
  upper_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == '0) |=> ctrl_q[TOT_W-1 -: REG_W] == $past(reg_wdata));

endmodule

// File: rtl/oc_chan.sv
module oc_chan
  import oc_pin_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  oc_act_e act,
  input  logic    evt,
  input  logic    mask,
  input  logic    dir,
  input  logic    pdata,
  output logic    lvl_q,
  output logic    timer_owns,
  output logic    pin_level,
  output logic    pin_oe
);
  logic evt_live;

  assign timer_owns = (act != ACT_OFF) && !mask;
  assign evt_live   = evt && timer_owns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lvl_q <= 1'b0;
    else if (evt_live) lvl_q <= act_next_level(act, lvl_q);
  end

  assign pin_oe    = timer_owns ? 1'b1  : dir;
  assign pin_level = timer_owns ? lvl_q : pdata;

  // R4
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !mask && act == ACT_TOGGLE) |=> (lvl_q != $past(lvl_q)));

  // R5
  set_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !mask && act == ACT_SET) |=> lvl_q);

  // R5
  clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !mask && act == ACT_CLEAR) |=> !lvl_q);

  // R7
  masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask || act == ACT_OFF) |=> $stable(lvl_q));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(lvl_q));

endmodule

// File: rtl/oc_pin_ctrl.sv
module oc_pin_ctrl
  import oc_pin_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int REG_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NCH-1:0]    cmp_evt,
  input  logic [NCH-1:0]    ovr_mask,
  input  logic [NCH-1:0]    ios_sel,
  input  logic [NCH-1:0]    dir_bits,
  input  logic [NCH-1:0]    port_data,
  output logic [NCH-1:0]    pin_level,
  output logic [NCH-1:0]    pin_oe,
  output logic              pa_free_hi,
  output logic              pa_free_lo
);
  localparam int TOP = NCH - 1;

  logic [2*NCH-1:0] ctrl_bits;
  logic [NCH-1:0]   lvl_q;
  logic [NCH-1:0]   timer_owns;
  logic [NCH-1:0]   pair_zero;

  oc_ctrl_regs #(.NCH(NCH), .REG_W(REG_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl_bits(ctrl_bits)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    oc_act_e act;
    assign act          = oc_act_e'(ctrl_bits[2*c+1 -: 2]);
    assign pair_zero[c] = (act == ACT_OFF);
    oc_chan chan_i (
      .clk(clk), .rst_n(rst_n), .act(act), .evt(cmp_evt[c]),
      .mask(ovr_mask[c]), .dir(dir_bits[c]), .pdata(port_data[c]),
      .lvl_q(lvl_q[c]), .timer_owns(timer_owns[c]),
      .pin_level(pin_level[c]), .pin_oe(pin_oe[c])
    );
  end

  assign pa_free_hi = ios_sel[TOP] && pair_zero[TOP] && !ovr_mask[TOP];
  assign pa_free_lo = ios_sel[0]   && pair_zero[0]   && !ovr_mask[0];

  // R6
  owned_pin_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe | dir_bits) == (timer_owns | dir_bits));

  // R7
  port_pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_level ^ port_data) & ~timer_owns) == '0);

  // R9
  pa_free_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pa_free_hi |-> !timer_owns[TOP]);

endmodule

// File: tb/oc_pin_ctrl_tb.sv
module oc_pin_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] cmp_evt = '0, ovr_mask = '0, ios_sel = '0, dir_bits = '0, port_data = '0;
  logic [7:0] pin_level, pin_oe;
  logic       pa_free_hi, pa_free_lo;

  int total = 0, bad = 0;
  logic finished = 1'b0;

  logic [7:0] m_hi = '0, m_lo = '0, m_lvl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oc_pin_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_evt(cmp_evt),
    .ovr_mask(ovr_mask), .ios_sel(ios_sel), .dir_bits(dir_bits),
    .port_data(port_data), .pin_level(pin_level), .pin_oe(pin_oe),
    .pa_free_hi(pa_free_hi), .pa_free_lo(pa_free_lo)
  );

  // {upper reg, lower reg, mask, dir, data, strobes}
  localparam logic [47:0] VEC [10] = '{
    48'h00_55_00_0F_A5_0F, 48'h00_55_00_F0_3C_05, 48'hFF_AA_00_00_00_FF,
    48'h55_FF_0F_FF_99_FF, 48'hA5_00_00_33_66_F0, 48'hC3_3C_81_55_AA_FF,
    48'h1B_E4_00_0F_F0_81, 48'h00_00_00_AA_55_FF, 48'h55_55_AA_00_FF_FF,
    48'hFF_FF_00_00_00_00
  };

  function automatic logic [1:0] m_pair(input int ch);
    logic [15:0] all;
    all = {m_hi, m_lo};
    return {all[2*ch+1], all[2*ch]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // apply strobes to the model with the present model setting
  task automatic m_strobe(input logic [7:0] e);
    for (int c = 0; c < 8; c++) begin
      if (e[c] && !ovr_mask[c]) begin
        case (m_pair(c))
          2'b01: m_lvl[c] = ~m_lvl[c];
          2'b10: m_lvl[c] = 1'b0;
          2'b11: m_lvl[c] = 1'b1;
          default: ;
        endcase
      end
    end
  endtask

  task automatic chk_pins(input string tag);
    logic [7:0] eo, el;
    #1;
    for (int c = 0; c < 8; c++) begin
      if (m_pair(c) != 2'b00 && !ovr_mask[c]) begin
        eo[c] = 1'b1; el[c] = m_lvl[c];
      end else begin
        eo[c] = dir_bits[c]; el[c] = port_data[c];
      end
    end
    chk({tag, " oe"}, pin_oe, eo);
    chk({tag, " level"}, pin_level, el);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 2'd0) m_hi = d;
    if (a == 2'd1) m_lo = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic strobe(input logic [7:0] e);
    @(negedge clk);
    cmp_evt = e;
    m_strobe(e);
    @(negedge clk);
    cmp_evt = '0;
  endtask

  initial begin
    for (int n = 0; n < 50000; n++) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    dir_bits = 8'h5A; port_data = 8'hC3; ios_sel = 8'h81;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_pins("R1 reset");
    rd("R1 upper reg", 2'd0, 8'h00);
    rd("R1 lower reg", 2'd1, 8'h00);
    chk("R1 R9 pa flags", {6'd0, pa_free_hi, pa_free_lo}, 8'h03);

    // R2 readback and layout
    wr(2'd0, 8'hE4);
    wr(2'd1, 8'h1B);
    rd("R2 upper readback", 2'd0, 8'hE4);
    rd("R2 lower readback", 2'd1, 8'h1B);
    // R3 undefined addresses
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hA5);
    rd("R3 addr2 reads 0", 2'd2, 8'h00);
    rd("R3 addr3 reads 0", 2'd3, 8'h00);
    rd("R3 upper intact", 2'd0, 8'hE4);
    rd("R3 lower intact", 2'd1, 8'h1B);

    // vector table: R4 R5 R6 R7
    foreach (VEC[i]) begin
      wr(2'd0, VEC[i][47:40]);
      wr(2'd1, VEC[i][39:32]);
      @(negedge clk);
      ovr_mask = VEC[i][31:24]; dir_bits = VEC[i][23:16]; port_data = VEC[i][15:8];
      strobe(VEC[i][7:0]);
      chk_pins($sformatf("R4 R5 R6 R7 vec%0d", i));
    end

    // R10 consecutive toggles on channel 1
    ovr_mask = '0;
    wr(2'd1, 8'h04);
    @(negedge clk);
    cmp_evt = 8'h02;
    for (int k = 0; k < 3; k++) begin
      m_strobe(8'h02);
      @(negedge clk);
      chk_pins($sformatf("R4 R10 back-to-back %0d", k));
    end
    cmp_evt = '0;
    repeat (2) @(negedge clk);
    chk_pins("R10 hold");

    // R7 masked strobe leaves level alone
    wr(2'd1, 8'h01);
    ovr_mask = 8'h01;
    strobe(8'h01);
    chk_pins("R7 masked pin");
    ovr_mask = 8'h00;
    chk_pins("R7 unmasked level kept");

    // R8 write concurrent with strobe uses old setting
    wr(2'd1, 8'h03);
    strobe(8'h01);
    chk_pins("R8 set first");
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h02;
    cmp_evt = 8'h01;
    m_strobe(8'h01);
    m_lo = 8'h02;
    @(negedge clk);
    reg_we = 1'b0; cmp_evt = '0;
    chk_pins("R8 old setting used");
    chk("R8 level still high", {7'd0, pin_level[0]}, 8'h01);
    strobe(8'h01);
    chk_pins("R8 new setting next");

    // R9 pulse accumulator flags
    wr(2'd0, 8'h3F);
    wr(2'd1, 8'hFC);
    ios_sel = 8'h81; ovr_mask = 8'h00;
    #1;
    chk("R9 both free", {6'd0, pa_free_hi, pa_free_lo}, 8'h03);
    ovr_mask = 8'h81;
    #1;
    chk("R9 mask blocks", {6'd0, pa_free_hi, pa_free_lo}, 8'h00);
    ovr_mask = 8'h00; ios_sel = 8'h01;
    #1;
    chk("R9 ios clear", {6'd0, pa_free_hi, pa_free_lo}, 8'h01);
    ios_sel = 8'h81;
    wr(2'd0, 8'h40);
    wr(2'd1, 8'hFD);
    #1;
    chk("R9 pair nonzero", {6'd0, pa_free_hi, pa_free_lo}, 8'h00);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule